// File: doc/BRIEF.md
# Serial Audio Interface Controller with Sample Queues

This block is a register-mapped stereo audio port for a standard two-channel serial audio link (I2S framing). Software writes stereo words into a four-entry transmit queue and reads captured stereo words from a four-entry receive queue. Each word packs the left sample in bits [31:16] and the right sample in bits [15:0]. The block generates the bit clock and the word-select clock from a programmable divider. It shifts transmit words out MSB first and captures the incoming data line on the same frame timing.

Two independent fill-level comparisons, one per queue, feed a single interrupt line. Each comparison has its own enable. Overruns and underruns are recorded in sticky error flags. Software clears a flag by writing a one to its position at the same offset used to read the flags. A control bit holds an external codec in reset. A test mode hands the serial pins and the interrupt line to a register, and exposes the incoming data line for reading.

Top module: `i2s_audio_ctrl`

## Requirements
- R1: After reset, CONTROL (0x000) reads 0 and DIVIDE (0x00C) reads 0x80. STATUS (0x004) reads 0x15. The bit clock, the interrupt and the codec reset outputs are low, and word select is high.
- R2: CONTROL holds these fields: transmit enable at bit 0, transmit interrupt enable at bit 1, receive enable at bit 2, receive interrupt enable at bit 3, transmit level at [6:4], receive level at [10:8] and codec reset at bit 17. The written value reads back, except for bit 16.
- R3: A write to 0x010 pushes a word into the four-entry transmit queue. A write to a full queue is dropped and sets the transmit error. STATUS reports transmit-empty at bit 0, transmit-full at bit 1, receive-empty at bit 2 and receive-full at bit 3.
- R4: The transmit alert (STATUS bit 4) is high when the number of free transmit entries is greater than the transmit level.
- R5: The receive alert (STATUS bit 5) is high when the number of free receive entries is less than the receive level.
- R6: The interrupt output equals (transmit alert AND transmit interrupt enable) OR (receive alert AND receive interrupt enable). With both enables low it stays low.
- R7: The error register at 0x008 reads transmit error at bit 0 and receive error at bit 1. Both flags are sticky. Writing 1 to a bit position at 0x008 clears only that flag. A read of 0x014 from an empty receive queue returns 0 and sets the receive error. A frame start with transmit enabled and an empty transmit queue sends zeros and sets the transmit error.
- R8: Writing CONTROL with bit 16 set empties both queues in that cycle. Bit 16 is not stored.
- R9: The codec reset output follows CONTROL bit 17 from the cycle after the write.
- R10: While transmit or receive is enabled (and test mode is off), the bit clock toggles once every DIVIDE system clocks. Otherwise it is held low.
- R11: Word select is low for the left half and high for the right half. It changes on bit-clock falling edges, with 16 bit-clock periods per half, and the left half comes first. Data goes out MSB first, one bit clock after each word-select change.
- R12: With receive enabled, the data input is sampled on bit-clock rising edges using the same framing. Each complete frame is pushed into the receive queue and read back in order from 0x014.
- R13: Writing 1 to bit 0 of 0x020 enables test mode. In test mode, bits [3:0] written to 0x024 drive the data output, the bit clock, word select and the interrupt, in that order. A read of 0x024 returns the data input in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the strobe |
| bit_clk_o | output | 1 | Serial bit clock |
| word_sel_o | output | 1 | Channel select, low = left |
| ser_data_o | output | 1 | Serial transmit data |
| ser_data_i | input | 1 | Serial receive data |
| irq_o | output | 1 | Level interrupt |
| codec_rst_o | output | 1 | External codec reset, active high |

## Verification
Register effects (queue levels, alerts, error flags, codec reset and interrupt) are due one clock after the write or read strobe. The bench therefore performs each access across one rising edge and samples on the following falling edge. Read data is combinational, so the bench takes it in the same cycle as the strobe, before the edge that pops the receive queue.

A behavioural monitor runs on every falling edge of the system clock. It checks that the bit clock half-period equals DIVIDE cycles and that word select holds for 16 bit-clock rising edges. Using a loopback, it decodes each frame from the data output on the bit-clock rises and compares it with a queue of written words. The frame word is due 32 bit-clock rises after the previous word-select fall. Receive words are read back only after the monitor has seen the matching frames complete.

// File: rtl/i2s_ctl_pkg.sv
package i2s_ctl_pkg;

    // register byte offsets
    localparam int OFS_CTRL  = 'h000;
    localparam int OFS_STAT  = 'h004;
    localparam int OFS_ERR   = 'h008;
    localparam int OFS_DIV   = 'h00C;
    localparam int OFS_TXD   = 'h010;
    localparam int OFS_RXD   = 'h014;
    localparam int OFS_TCTL  = 'h020;
    localparam int OFS_TPIN  = 'h024;

    localparam int FLUSH_BIT = 16;

    typedef struct packed {
        logic       codec_rst;
        logic [2:0] rx_lvl;
        logic [2:0] tx_lvl;
        logic       rx_ie;
        logic       rx_en;
        logic       tx_ie;
        logic       tx_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.tx_en     = w[0];
        c.tx_ie     = w[1];
        c.rx_en     = w[2];
        c.rx_ie     = w[3];
        c.tx_lvl    = w[6:4];
        c.rx_lvl    = w[10:8];
        c.codec_rst = w[17];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c);
        logic [31:0] w;
        w       = '0;
        w[0]    = c.tx_en;
        w[1]    = c.tx_ie;
        w[2]    = c.rx_en;
        w[3]    = c.rx_ie;
        w[6:4]  = c.tx_lvl;
        w[10:8] = c.rx_lvl;
        w[17]   = c.codec_rst;
        return w;
    endfunction

endpackage

// File: rtl/i2s_sample_fifo.sv
module i2s_sample_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic [W-1:0]  data_i,
    input  logic          pop_i,
    output logic [W-1:0]  data_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t cur_q, nxt_d;
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        nxt_d   = cur_q;
        do_pop  = pop_i && (cur_q.cnt != '0);
        do_push = push_i && ((cur_q.cnt != CW'(DEPTH)) || do_pop);
        if (flush_i) begin
            nxt_d.wp  = '0;
            nxt_d.rp  = '0;
            nxt_d.cnt = '0;
        end else begin
            if (do_push) begin
                nxt_d.mem[cur_q.wp] = data_i;
                nxt_d.wp            = bump(cur_q.wp);
            end
            if (do_pop) nxt_d.rp = bump(cur_q.rp);
            case ({do_push, do_pop})
                2'b10:   nxt_d.cnt = cur_q.cnt + 1'b1;
                2'b01:   nxt_d.cnt = cur_q.cnt - 1'b1;
                default: nxt_d.cnt = cur_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign data_o  = cur_q.mem[cur_q.rp];
    assign count_o = cur_q.cnt;
    assign full_o  = (cur_q.cnt == CW'(DEPTH));
    assign empty_o = (cur_q.cnt == '0);

    // R3: occupancy never exceeds the depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= CW'(DEPTH));

    // R3: a push into a full queue without a pop leaves the level unchanged
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i && !flush_i) |=> $stable(cur_q.cnt));

endmodule

// File: rtl/i2s_serial_engine.sv
module i2s_serial_engine #(
    parameter int W     = 32,
    parameter int DIV_W = 16,
    localparam int BCW  = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tx_en_i,
    input  logic             rx_en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [W-1:0]     tx_word_i,
    input  logic             tx_avail_i,
    input  logic             ser_i,
    output logic             tx_pop_o,
    output logic             tx_under_o,
    output logic             rx_push_o,
    output logic [W-1:0]     rx_word_o,
    output logic             sclk_o,
    output logic             ws_o,
    output logic             sd_o
);

    typedef struct packed {
        logic [DIV_W-1:0] divcnt;
        logic             sclk;
        logic [BCW-1:0]   bcnt;
        logic [W-1:0]     tsh;
        logic             sd;
        logic [W-1:0]     rsh;
        logic             armed;
    } eng_st_t;

    eng_st_t cur_q, nxt_d;
    logic [DIV_W-1:0] lim;

    always_comb begin
        nxt_d      = cur_q;
        tx_pop_o   = 1'b0;
        tx_under_o = 1'b0;
        rx_push_o  = 1'b0;
        lim        = (div_i == '0) ? DIV_W'(1) : div_i;
        if (!run_i) begin
            nxt_d.divcnt = '0;
            nxt_d.sclk   = 1'b0;
            nxt_d.bcnt   = '1;
            nxt_d.tsh    = '0;
            nxt_d.sd     = 1'b0;
            nxt_d.armed  = 1'b0;
        end else if (cur_q.divcnt == lim - 1'b1) begin
            nxt_d.divcnt = '0;
            nxt_d.sclk   = !cur_q.sclk;
            if (!cur_q.sclk) begin
                // rising edge: capture one bit
                nxt_d.rsh = {cur_q.rsh[W-2:0], ser_i};
                if (cur_q.bcnt == BCW'(1)) nxt_d.armed = rx_en_i;
                if (cur_q.bcnt == '0 && cur_q.armed && rx_en_i) rx_push_o = 1'b1;
            end else begin
                // falling edge: advance slot, shift one bit out
                nxt_d.bcnt = cur_q.bcnt + 1'b1;
                nxt_d.sd   = cur_q.tsh[W-1];
                nxt_d.tsh  = {cur_q.tsh[W-2:0], 1'b0};
                if (nxt_d.bcnt == '0) begin
                    if (tx_en_i && tx_avail_i) begin
                        nxt_d.tsh = tx_word_i;
                        tx_pop_o  = 1'b1;
                    end else begin
                        nxt_d.tsh  = '0;
                        tx_under_o = tx_en_i;
                    end
                end
            end
        end else begin
            nxt_d.divcnt = cur_q.divcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.bcnt <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rx_word_o = nxt_d.rsh;
    assign sclk_o    = cur_q.sclk;
    assign ws_o      = cur_q.bcnt[BCW-1];
    assign sd_o      = cur_q.sd;

    // R10: a stopped engine parks the bit clock low
    assert_idle_clock_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !cur_q.sclk);

    // R11: word select only moves together with a bit-clock fall
    assert_ws_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_i) && ($past(ws_o) != ws_o)) |-> ($past(sclk_o) && !sclk_o));

endmodule

// File: rtl/i2s_audio_ctrl.sv
module i2s_audio_ctrl
    import i2s_ctl_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DEPTH     = 4,
    parameter int SAMPLE_W  = 16,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 'h80,
    localparam int WORD_W   = 2 * SAMPLE_W,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              bit_clk_o,
    output logic              word_sel_o,
    output logic              ser_data_o,
    input  logic              ser_data_i,
    output logic              irq_o,
    output logic              codec_rst_o
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [DIV_W-1:0] div;
        logic             tx_err;
        logic             rx_err;
        logic             test_en;
        logic [3:0]       test_pins;
    } top_st_t;

    top_st_t cur_q, nxt_d;

    logic wr_acc, rd_acc, flush, tx_push, rx_pop, run;
    logic tx_over, rx_over, rx_under, tx_alert, rx_alert, irq_norm;
    logic [WORD_W-1:0] tx_head, rx_head, eng_rx_word;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic eng_pop, eng_under, eng_push, eng_sclk, eng_ws, eng_sd;

    function automatic logic at(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign wr_acc  = bus_sel_i && bus_wr_i;
    assign rd_acc  = bus_sel_i && !bus_wr_i;
    assign flush   = wr_acc && at(bus_addr_i, OFS_CTRL) && bus_wdata_i[FLUSH_BIT];
    assign tx_push = wr_acc && at(bus_addr_i, OFS_TXD);
    assign rx_pop  = rd_acc && at(bus_addr_i, OFS_RXD);
    assign run     = (cur_q.ctrl.tx_en || cur_q.ctrl.rx_en) && !cur_q.test_en;

    i2s_sample_fifo #(.W(WORD_W), .DEPTH(DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .push_i(tx_push), .data_i(bus_wdata_i[WORD_W-1:0]), .pop_i(eng_pop),
        .data_o(tx_head), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
    );

    i2s_sample_fifo #(.W(WORD_W), .DEPTH(DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .push_i(eng_push), .data_i(eng_rx_word), .pop_i(rx_pop),
        .data_o(rx_head), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
    );

    i2s_serial_engine #(.W(WORD_W), .DIV_W(DIV_W)) engine_i (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .tx_en_i(cur_q.ctrl.tx_en), .rx_en_i(cur_q.ctrl.rx_en), .div_i(cur_q.div),
        .tx_word_i(tx_head), .tx_avail_i(!tx_empty), .ser_i(ser_data_i),
        .tx_pop_o(eng_pop), .tx_under_o(eng_under),
        .rx_push_o(eng_push), .rx_word_o(eng_rx_word),
        .sclk_o(eng_sclk), .ws_o(eng_ws), .sd_o(eng_sd)
    );

    always_comb begin
        tx_over  = tx_push && tx_full && !eng_pop && !flush;
        rx_over  = eng_push && rx_full && !rx_pop;
        rx_under = rx_pop && rx_empty;
        tx_alert = (int'(DEPTH) - int'(tx_cnt)) > int'(cur_q.ctrl.tx_lvl);
        rx_alert = (int'(DEPTH) - int'(rx_cnt)) < int'(cur_q.ctrl.rx_lvl);
        irq_norm = (tx_alert && cur_q.ctrl.tx_ie) || (rx_alert && cur_q.ctrl.rx_ie);

        nxt_d = cur_q;
        if (wr_acc && at(bus_addr_i, OFS_CTRL)) nxt_d.ctrl = ctrl_unpack(bus_wdata_i);
        if (wr_acc && at(bus_addr_i, OFS_DIV))  nxt_d.div  = bus_wdata_i[DIV_W-1:0];
        if (wr_acc && at(bus_addr_i, OFS_TCTL)) nxt_d.test_en   = bus_wdata_i[0];
        if (wr_acc && at(bus_addr_i, OFS_TPIN)) nxt_d.test_pins = bus_wdata_i[3:0];
        nxt_d.tx_err = (cur_q.tx_err && !(wr_acc && at(bus_addr_i, OFS_ERR) && bus_wdata_i[0]))
                       || tx_over || eng_under;
        nxt_d.rx_err = (cur_q.rx_err && !(wr_acc && at(bus_addr_i, OFS_ERR) && bus_wdata_i[1]))
                       || rx_over || rx_under;

        bus_rdata_o = '0;
        if (at(bus_addr_i, OFS_CTRL)) bus_rdata_o = ctrl_pack(cur_q.ctrl);
        if (at(bus_addr_i, OFS_STAT)) bus_rdata_o = {26'b0, rx_alert, tx_alert,
                                                     rx_full, rx_empty, tx_full, tx_empty};
        if (at(bus_addr_i, OFS_ERR))  bus_rdata_o = {30'b0, cur_q.rx_err, cur_q.tx_err};
        if (at(bus_addr_i, OFS_DIV))  bus_rdata_o = 32'(cur_q.div);
        if (at(bus_addr_i, OFS_RXD))  bus_rdata_o = rx_empty ? '0 : 32'(rx_head);
        if (at(bus_addr_i, OFS_TCTL)) bus_rdata_o = {31'b0, cur_q.test_en};
        if (at(bus_addr_i, OFS_TPIN)) bus_rdata_o = {31'b0, ser_data_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= '0;
            cur_q.div <= DIV_W'(DIV_RESET);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ser_data_o  = cur_q.test_en ? cur_q.test_pins[0] : eng_sd;
    assign bit_clk_o   = cur_q.test_en ? cur_q.test_pins[1] : eng_sclk;
    assign word_sel_o  = cur_q.test_en ? cur_q.test_pins[2] : eng_ws;
    assign irq_o       = cur_q.test_en ? cur_q.test_pins[3] : irq_norm;
    assign codec_rst_o = cur_q.ctrl.codec_rst;

    // R9: codec reset follows the written control bit one cycle later
    assert_codec_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && at(bus_addr_i, OFS_CTRL)) |=> (codec_rst_o == $past(bus_wdata_i[17])));

    // R7: transmit error stays set until a matching clear write
    assert_tx_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.tx_err && !(wr_acc && at(bus_addr_i, OFS_ERR) && bus_wdata_i[0]))
        |=> cur_q.tx_err);

    // R7: receive error stays set until a matching clear write
    assert_rx_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.rx_err && !(wr_acc && at(bus_addr_i, OFS_ERR) && bus_wdata_i[1]))
        |=> cur_q.rx_err);

    // R6: no interrupt when both interrupt enables are off
    assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.test_en && !cur_q.ctrl.tx_ie && !cur_q.ctrl.rx_ie) |-> !irq_o);

endmodule

// File: tb/i2s_audio_ctrl_tb_top.sv
module i2s_audio_ctrl_tb_top;

    localparam int DIVN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        bclk, wsel, sdo, irq, crst;
    logic        loop_en = 1'b0, tb_sd = 1'b0;
    logic        sdi;

    int vecs = 0, fails = 0;

    assign sdi = loop_en ? sdo : tb_sd;

    always #5 clk = ~clk;

    i2s_audio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .bit_clk_o(bclk), .word_sel_o(wsel), .ser_data_o(sdo), .ser_data_i(sdi),
        .irq_o(irq), .codec_rst_o(crst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    // behavioural monitor state (reference model)
    logic        mon_on = 1'b0;
    logic [31:0] exp_q[$];
    logic        prev_bclk = 1'b0, prev_ws = 1'b1, last_ws = 1'b1, ws_seen = 1'b0, tog_seen = 1'b0;
    logic [31:0] mon_sh = '0;
    int          mon_n = 0, mon_words = 0, half_cyc = 0, rises_in_half = 0;

    always @(negedge clk) begin
        if (!mon_on) begin
            prev_bclk = bclk; prev_ws = 1'b1; last_ws = wsel;
            ws_seen = 1'b0; tog_seen = 1'b0; mon_n = 0; half_cyc = 0; rises_in_half = 0;
        end else begin
            half_cyc++;
            if (bclk != prev_bclk) begin
                if (tog_seen) chk("R10 bit clock half period", half_cyc, DIVN);
                tog_seen = 1'b1;
                half_cyc = 0;
            end
            if (wsel != last_ws) begin
                if (ws_seen) chk("R11 rises per word-select half", rises_in_half, 16);
                ws_seen = 1'b1;
                rises_in_half = 0;
                last_ws = wsel;
            end
            if (bclk && !prev_bclk) begin
                rises_in_half++;
                mon_sh = {mon_sh[30:0], sdo};
                mon_n++;
                if (prev_ws && !wsel) begin
                    if (mon_n == 32) begin
                        if (exp_q.size() > 0) chk("R11 serial frame", mon_sh, exp_q.pop_front());
                        else chk("R11 unexpected frame", mon_sh, 32'hxxxx_xxxx);
                        mon_words++;
                    end
                    mon_n = 0;
                end
                prev_ws = wsel;
            end
            prev_bclk = bclk;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] words [3];
        int guard;
        words[0] = 32'hA5C3_1E0F;
        words[1] = 32'h8001_7FFE;
        words[2] = 32'h1234_ABCD;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(8'h00, d); chk("R1 control reset", d, 32'h0);
        bus_rd(8'h0C, d); chk("R1 divide reset", d, 32'h80);
        bus_rd(8'h04, d); chk("R1 status reset", d, 32'h15);
        chk("R1 pins at reset", {28'b0, bclk, wsel, irq, crst}, 32'b0100);

        // R2 field readback, flush bit not stored
        bus_wr(8'h00, 32'h0001_077A);
        bus_rd(8'h00, d); chk("R2 control readback", d, 32'h0000_077A);

        // R3/R4 fill the transmit queue with level 2 (engine stopped)
        bus_wr(8'h00, 32'h20);
        for (int n = 1; n <= 4; n++) begin
            bus_wr(8'h10, 32'h1111_0000 + n);
            bus_rd(8'h04, d);
            chk("R3/R4 status while filling", d,
                ((n == 4) ? 32'h2 : 32'h0) | 32'h4 | (((4 - n) > 2) ? 32'h10 : 32'h0));
        end
        bus_wr(8'h10, 32'hDEAD_BEEF);
        bus_rd(8'h08, d); chk("R3 overrun sets transmit error", d, 32'h1);
        bus_wr(8'h08, 32'h2);
        bus_rd(8'h08, d); chk("R7 clear of other bit keeps flag", d, 32'h1);
        bus_wr(8'h08, 32'h1);
        bus_rd(8'h08, d); chk("R7 write-one clear", d, 32'h0);

        // R6/R8 interrupt and flush
        bus_wr(8'h00, 32'h02);
        #1 chk("R6 full queue level 0 no irq", irq, 1'b0);
        bus_wr(8'h00, 32'h0001_0002);
        bus_rd(8'h04, d); chk("R8 flush empties queues", d, 32'h15);
        #1 chk("R6 transmit alert raises irq", irq, 1'b1);

        // R5 receive alert
        bus_wr(8'h00, 32'h408);
        #1 chk("R5 receive level 4 with 4 free", irq, 1'b0);
        bus_wr(8'h00, 32'h508);
        bus_rd(8'h04, d); chk("R5 receive alert level 5", d, 32'h35);
        #1 chk("R5/R6 receive alert irq", irq, 1'b1);

        // R7 receive underrun
        bus_wr(8'h00, 32'h0);
        bus_rd(8'h14, d); chk("R7 empty read returns zero", d, 32'h0);
        bus_rd(8'h08, d); chk("R7 underrun sets receive error", d, 32'h2);
        bus_wr(8'h08, 32'h3);

        // R9 codec reset
        bus_wr(8'h00, 32'h0002_0000);
        #1 chk("R9 codec reset high", crst, 1'b1);
        bus_wr(8'h00, 32'h0);
        #1 chk("R9 codec reset low", crst, 1'b0);

        // R13 test mode
        bus_wr(8'h20, 32'h1);
        bus_wr(8'h24, 32'hF);
        #1 chk("R13 pins driven high", {28'b0, irq, wsel, bclk, sdo}, 32'hF);
        bus_wr(8'h24, 32'h5);
        #1 chk("R13 pins pattern", {28'b0, irq, wsel, bclk, sdo}, 32'h5);
        tb_sd = 1'b1;
        bus_rd(8'h24, d); chk("R13 data input high", d, 32'h1);
        tb_sd = 1'b0;
        bus_rd(8'h24, d); chk("R13 data input low", d, 32'h0);
        bus_wr(8'h20, 32'h0);
        #1 chk("R13 pins released", {30'b0, wsel, bclk}, 32'b10);

        // R10/R11/R12 loopback streaming
        bus_wr(8'h0C, DIVN);
        bus_rd(8'h0C, d); chk("R10 divide readback", d, DIVN);
        for (int i = 0; i < 3; i++) begin
            bus_wr(8'h10, words[i]);
            exp_q.push_back(words[i]);
        end
        loop_en = 1'b1;
        mon_on = 1'b1;
        bus_wr(8'h00, 32'h5);
        guard = 0;
        while (mon_words < 3 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        chk("R11 frames observed", mon_words, 3);
        mon_on = 1'b0;
        bus_wr(8'h00, 32'h0);
        #1 chk("R10 bit clock parked low", bclk, 1'b0);
        for (int i = 0; i < 3; i++) begin
            bus_rd(8'h14, d);
            chk("R12 received word in order", d, words[i]);
        end
        bus_rd(8'h04, d); chk("R12 queues drained", d, 32'h15);
        bus_rd(8'h08, d); chk("R7 transmit underrun flagged", d, 32'h1);

        finish_run();
    end

endmodule